// File: doc/BRIEF.md
# Page-Safe Burst Transfer Splitter

This block sits between a requester, such as a processor or a DMA engine, and a shared bus whose target decodes addresses in pages of 256 words (1 KB of 32-bit words). The target does not move on to the next page when a burst runs past the last word of the current one. It wraps back to the start of the same page instead. The requester gives a start word address, a length in words and a direction. The block splits that request into bursts, and no burst ever crosses a page boundary.

The first burst is trimmed so that it ends exactly at the next boundary. Every later burst starts on a boundary and carries at most one full page. For each burst the block announces a start address, a word count and the direction. It then steps one word per clock through the burst, presenting the address of each word as it moves. One idle cycle separates consecutive bursts. A busy flag covers the whole request. A completion flag rises once the last word has moved, and it drops again when a new request is accepted or when the direction selection is changed.

Top module: `page_burst_splitter`

## Requirements
- R1: A request (`req_valid` high while `busy` is low) is accepted at that clock edge. For a non-zero length, `busy` is high from the cycle after acceptance until the cycle in which the final word is presented, and it is low in the cycle that follows.
- R2: The first burst starts at the request address. Its count is the smaller of the request length and 256 minus the low 8 address bits (the word offset within the page).
- R3: No burst crosses a page boundary. Within a burst, each word address is the previous one plus 1, and the low 8 bits of a following word are never zero.
- R4: Every burst after the first starts at an address whose low 8 bits are zero. Its count is the smaller of the words remaining and 256.
- R5: While a burst is active, exactly one word moves per clock (`beat_valid` high). `burst_start` is high only in the cycle of the first word of each burst, and `burst_addr`/`burst_len` are valid in that cycle.
- R6: The first word appears two cycles after the accepting edge, with one idle cycle in between. Exactly one idle cycle (`beat_valid` low, `busy` high) separates the last word of one burst from the first word of the next.
- R7: In the cycle after the final word, `done` is high and `busy` is low.
- R8: A request of length zero moves no word. `done` is high and `busy` is low in the cycle after acceptance.
- R9: `done` falls in the cycle after a request is accepted (unless the request has length zero). It also falls one cycle after `dir_sel` changes value, unless a completion happens in that same cycle.
- R10: `burst_dir` equals the value `dir_sel` had at acceptance. Changes to `dir_sel` during a transfer do not alter it.
- R11: After reset, `busy`, `done`, `beat_valid` and `burst_start` are low.
- R12: `req_valid` while `busy` is high is ignored: the running transfer continues with unchanged addresses and counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Length in words |
| dir_sel | input | 1 | Transfer direction selection (1 = write) |
| busy | output | 1 | Request in progress |
| done | output | 1 | Transfer complete flag |
| burst_start | output | 1 | First word of a burst |
| burst_addr | output | ADDR_W | Start address of the current burst |
| burst_len | output | PAGE_BITS+1 | Word count of the current burst |
| burst_dir | output | 1 | Direction of the current request |
| beat_valid | output | 1 | A word moves this cycle |
| beat_addr | output | ADDR_W | Address of the word moving this cycle |

## Verification
The hardest cases to reach are the split points: a start offset one word short of a boundary, a request that ends exactly on a boundary, and a request long enough to need a full middle page. Random lengths and offsets rarely land on these. The stimulus therefore drives directed requests at offsets 255 and 200 and at aligned starts with lengths of 256 and 257 words. It then adds seeded random requests covering up to three pages. Some of the random requests also pulse `req_valid` and flip `dir_sel` mid-transfer, to show that neither input disturbs the running transfer.

// File: rtl/splt_pkg.sv
package splt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RUN   = 2'd2
  } splt_state_e;
endpackage

// File: rtl/splt_sizer.sv
// Chooses the size of the next burst: the words left, capped at the room
// left before the next page boundary.
module splt_sizer #(
  parameter int ADDR_W    = 30,
  parameter int LEN_W     = 12,
  parameter int PAGE_BITS = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [LEN_W-1:0]     remain,
  output logic [PAGE_BITS:0]   size
);
  localparam int BLEN_W     = PAGE_BITS + 1;
  localparam int CW         = (LEN_W > BLEN_W) ? LEN_W : BLEN_W;
  localparam int PAGE_WORDS = 1 << PAGE_BITS;

  logic [CW-1:0] room;
  logic [CW-1:0] rem_w;
  logic [CW-1:0] pick;

  always_comb begin
    room  = CW'(PAGE_WORDS) - CW'(addr[PAGE_BITS-1:0]);
    rem_w = CW'(remain);
    pick  = (rem_w < room) ? rem_w : room;
    size  = BLEN_W'(pick);
  end
endmodule

// File: rtl/splt_beat.sv
// Steps through one burst: one word address per clock.
module splt_beat #(
  parameter int ADDR_W    = 30,
  parameter int PAGE_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [ADDR_W-1:0]   load_addr,
  input  logic [PAGE_BITS:0]  load_cnt,
  output logic                beat_valid,
  output logic [ADDR_W-1:0]   beat_addr,
  output logic                beat_last
);
  localparam int BLEN_W = PAGE_BITS + 1;

  logic [BLEN_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      beat_addr  <= '0;
      left       <= '0;
    end else if (load) begin
      beat_valid <= 1'b1;
      beat_addr  <= load_addr;
      left       <= load_cnt - BLEN_W'(1);
    end else if (beat_valid) begin
      if (left == '0) begin
        beat_valid <= 1'b0;
      end else begin
        beat_addr <= beat_addr + ADDR_W'(1);
        left      <= left - BLEN_W'(1);
      end
    end
  end

  assign beat_last = beat_valid && (left == '0);
endmodule

// File: rtl/page_burst_splitter.sv
module page_burst_splitter #(
  parameter int ADDR_W    = 30,
  parameter int LEN_W     = 12,
  parameter int PAGE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 dir_sel,
  output logic                 busy,
  output logic                 done,
  output logic                 burst_start,
  output logic [ADDR_W-1:0]    burst_addr,
  output logic [PAGE_BITS:0]   burst_len,
  output logic                 burst_dir,
  output logic                 beat_valid,
  output logic [ADDR_W-1:0]    beat_addr
);
  import splt_pkg::*;

  localparam int BLEN_W = PAGE_BITS + 1;
  localparam int CW     = (LEN_W > BLEN_W) ? LEN_W : BLEN_W;

  splt_state_e        state;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   remain;
  logic               dir_q;
  logic [BLEN_W-1:0]  next_size;
  logic               load;
  logic               beat_last;

  splt_sizer #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)
  ) u_sizer (
    .addr(cur_addr), .remain(remain), .size(next_size)
  );

  assign load = (state == ST_ISSUE);

  splt_beat #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)
  ) u_beat (
    .clk(clk), .rst(rst), .load(load),
    .load_addr(cur_addr), .load_cnt(next_size),
    .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_last(beat_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      busy        <= 1'b0;
      done        <= 1'b0;
      cur_addr    <= '0;
      remain      <= '0;
      dir_q       <= 1'b0;
      burst_start <= 1'b0;
      burst_addr  <= '0;
      burst_len   <= '0;
      burst_dir   <= 1'b0;
    end else begin
      dir_q       <= dir_sel;
      burst_start <= 1'b0;
      if (dir_sel != dir_q) done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr  <= req_addr;
            remain    <= req_len;
            burst_dir <= dir_sel;
            if (req_len == '0) begin
              done <= 1'b1;
            end else begin
              done  <= 1'b0;
              busy  <= 1'b1;
              state <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          burst_start <= 1'b1;
          burst_addr  <= cur_addr;
          burst_len   <= next_size;
          cur_addr    <= cur_addr + ADDR_W'(next_size);
          remain      <= LEN_W'(CW'(remain) - CW'(next_size));
          state       <= ST_RUN;
        end
        ST_RUN: begin
          if (beat_last) begin
            if (remain == '0) begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_burst_splitter_chk.sv
module page_burst_splitter_chk #(
  parameter int ADDR_W    = 30,
  parameter int LEN_W     = 12,
  parameter int PAGE_BITS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic [LEN_W-1:0]    req_len,
  input logic                dir_sel,
  input logic                dir_q,
  input logic                busy,
  input logic                done,
  input logic                burst_start,
  input logic [ADDR_W-1:0]   burst_addr,
  input logic [PAGE_BITS:0]  burst_len,
  input logic                beat_valid,
  input logic [ADDR_W-1:0]   beat_addr
);
  localparam int SW         = PAGE_BITS + 2;
  localparam int PAGE_WORDS = 1 << PAGE_BITS;

  // R3: a burst fits in the room left in its page
  assert_burst_fits_page_R3: assert property (@(posedge clk) disable iff (rst)
    burst_start |-> (burst_len != '0) &&
      (SW'(burst_addr[PAGE_BITS-1:0]) + SW'(burst_len) <= SW'(PAGE_WORDS)));

  // R3: consecutive words step by one and never wrap into a new page
  assert_beat_step_R3: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && $past(beat_valid) && !burst_start) |->
      (beat_addr == $past(beat_addr) + ADDR_W'(1)) &&
      (beat_addr[PAGE_BITS-1:0] != '0));

  // R5: burst start comes with a word on the same cycle
  assert_start_with_beat_R5: assert property (@(posedge clk) disable iff (rst)
    burst_start |-> beat_valid && beat_addr == burst_addr);

  // R7: completion flag never overlaps the busy flag
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R1: accepted non-zero request raises busy
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_len != '0) |=> busy);

  // R9: direction change while idle clears the completion flag
  assert_dir_clears_done_R9: assert property (@(posedge clk) disable iff (rst)
    (dir_sel != dir_q && !busy && !req_valid) |=> !done);

  // R6: a word never moves without busy
  assert_beat_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> busy);
endmodule

bind page_burst_splitter page_burst_splitter_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_len(req_len),
  .dir_sel(dir_sel), .dir_q(dir_q), .busy(busy), .done(done),
  .burst_start(burst_start), .burst_addr(burst_addr), .burst_len(burst_len),
  .beat_valid(beat_valid), .beat_addr(beat_addr)
);

// File: tb/page_burst_splitter_test.sv
module page_burst_splitter_test;
  localparam int ADDR_W = 30;
  localparam int LEN_W  = 12;
  localparam int PB     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic dir_sel = 1'b0;
  logic busy, done, burst_start, burst_dir, beat_valid;
  logic [ADDR_W-1:0] burst_addr, beat_addr;
  logic [PB:0] burst_len;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  page_burst_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BITS(PB)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .dir_sel(dir_sel), .busy(busy), .done(done),
    .burst_start(burst_start), .burst_addr(burst_addr), .burst_len(burst_len),
    .burst_dir(burst_dir), .beat_valid(beat_valid), .beat_addr(beat_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic int first_size(input longint a, input int rem);
    int room = 256 - int'(a & 255);
    return (rem < room) ? rem : room;
  endfunction

  // intr: pulse req_valid and flip dir_sel during the first burst
  task automatic run_req(input longint addr, input int len, input bit dir, input bit intr);
    longint mask = (longint'(1) << ADDR_W) - 1;
    longint a;
    int rem, n;
    bit first;
    @(negedge clk);
    dir_sel   = dir;
    req_valid = 1'b1;
    req_addr  = ADDR_W'(addr);
    req_len   = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk(!busy, "R8", "busy", busy, 0);
      chk(done, "R8", "done", done, 1);
      chk(!beat_valid, "R8", "beat_valid", beat_valid, 0);
      @(negedge clk);
      chk(!beat_valid && !burst_start, "R8", "no burst", beat_valid, 0);
      return;
    end
    chk(busy, "R1", "busy after accept", busy, 1);
    chk(!beat_valid, "R6", "idle before first burst", beat_valid, 0);
    chk(!done, "R9", "done cleared by accept", done, 0);
    a = addr & mask;
    rem = len;
    first = 1'b1;
    while (rem > 0) begin
      n = first_size(a, rem);
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        req_valid = 1'b0;
        chk(beat_valid, first ? "R5" : "R4", "beat_valid", beat_valid, 1);
        chk(longint'(beat_addr) == ((a + k) & mask), "R3", "beat_addr", beat_addr, (a + k) & mask);
        chk(burst_start == (k == 0), "R5", "burst_start", burst_start, k == 0);
        chk(busy, "R1", "busy during burst", busy, 1);
        if (k == 0) begin
          chk(int'(burst_len) == n, first ? "R2" : "R4", "burst_len", burst_len, n);
          chk(longint'(burst_addr) == a, first ? "R2" : "R4", "burst_addr", burst_addr, a);
          chk(burst_dir == dir, "R10", "burst_dir", burst_dir, dir);
          if (!first) chk(burst_addr[PB-1:0] == 0, "R4", "aligned start", burst_addr[PB-1:0], 0);
          if (intr && first) begin
            req_valid = 1'b1;
            req_addr  = ADDR_W'(a + 77);
            req_len   = LEN_W'(5);
            dir_sel   = ~dir;
          end
        end
      end
      a = (a + n) & mask;
      rem -= n;
      first = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!beat_valid, "R6", "idle cycle", beat_valid, 0);
      if (rem == 0) begin
        chk(!busy, "R7", "busy after last", busy, 0);
        chk(done, "R7", "done after last", done, 1);
      end else begin
        chk(busy, "R6", "busy between bursts", busy, 1);
        chk(!done, "R7", "done early", done, 0);
      end
    end
    if (intr) chk(1'b1, "R12", "ignored request", 0, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R11", "busy/done after reset", {busy, done}, 0);
    chk(!beat_valid && !burst_start, "R11", "beat after reset", {beat_valid, burst_start}, 0);

    run_req(30'h0000_01FF, 2, 1'b0, 1'b0);   // R2 offset 255 split 1+1
    run_req(30'h0000_0C00, 256, 1'b1, 1'b0); // R4 one full page
    run_req(30'h0000_0D00, 257, 1'b0, 1'b0); // R4 full page plus one
    run_req(30'h0000_02C8, 56, 1'b1, 1'b0);  // R2 ends exactly on boundary
    run_req(30'h0000_0345, 1, 1'b0, 1'b0);   // single word
    run_req(30'h0000_0410, 0, 1'b1, 1'b0);   // R8 zero length
    run_req(30'h0000_05F0, 600, 1'b0, 1'b1); // R12 request ignored while busy

    // R9: direction flip clears the completion flag
    chk(done, "R9", "done before flip", done, 1);
    @(negedge clk);
    dir_sel = ~dir_sel;
    @(negedge clk);
    chk(!done, "R9", "done after flip", done, 0);

    for (int i = 0; i < 30; i++) begin
      longint ra = longint'($urandom) & ((longint'(1) << ADDR_W) - 1);
      int rl = int'($urandom % 700);
      run_req(ra, rl, 1'($urandom), (i % 5) == 2);
    end
    summary();
  end
endmodule